// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is a four-bit decade counter made of two sections: a toggle stage holding bit 0 (divide by two) and a five-state stage holding bits 3..1 (divide by five). Each section has its own count-enable pulse, `cnt_c1` for the toggle stage and `cnt_c2` for the five-state stage. Both pulses are sampled on one system clock. A mode input sets how the sections are chained. In BCD mode the toggle stage carries into the five-state stage, so pulsing `cnt_c1` gives a plain 8421 decade count. In bi-quinary mode the five-state stage carries into the toggle stage, so pulsing `cnt_c2` gives counts 0–4 with bit 0 low and then counts 5–9 with bit 0 high. Used without the carry, each section divides by its own modulus.

Every bit has its own set line, and one common clear line acts on all bits. These force lines act on the outputs at once, without waiting for a clock. While any of them is held, counting is frozen, and the forced value is stored so that counting continues from it once the lines are released. The bench tests the force lines against bits 0 and 3, and the block also provides complements of those two bits and a terminal-count flag.

Top module: `biq_counter`

## Requirements
- R1: A synchronous `rst` high on a rising clock edge clears the stored count to 0000. With no force line active, this gives `q`=0000, `q0_n`=1, `q3_n`=1 and `tc`=0.
- R2: With `mode`=0 (BCD), each `cnt_c1` pulse steps `q` (bit 3 down to bit 0) through binary 0000..1001. From 1001 it returns to 0000.
- R3: With `mode`=1 (bi-quinary), each `cnt_c2` pulse steps count n from 0 to 9 and then back to 0. Here `q[0]` = (n ≥ 5) and `{q[3],q[2],q[1]}` = n mod 5 as a binary number.
- R4: `cnt_c1` toggles `q[0]`, and `cnt_c2` advances the five-state stage (bits 3..1: 000→001→010→011→100→000), in either mode. The toggle stage carries into the five-state stage only in BCD mode, when it wraps 1→0. The five-state stage carries into the toggle stage only in bi-quinary mode, when it wraps 100→000. A carry that arrives together with the stage's own pulse advances that stage only once.
- R5: `set_bits[i]` high drives `q[i]` to 1 immediately, with no clock edge needed.
- R6: `clear_all` high drives to 0 immediately every bit whose `set_bits` line is low. A bit that is both set and cleared reads 1.
- R7: While any force line is high, count pulses are ignored and the forced value is stored. After release, counting resumes from that value on the next pulse.
- R8: A five-state value with bit 3 high and bit 2 or bit 1 also high can only be reached through the set lines. Such a value goes to 000 on the next advance of that stage, with no carry.
- R9: `q0_n` is always the complement of `q[0]`, and `q3_n` is always the complement of `q[3]`.
- R10: `tc` is high exactly when `q` = 1001. This is count 9 in both modes.
- R11: With no count pulse and no force line active, `q` holds its value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = BCD chaining, 1 = bi-quinary chaining |
| cnt_c1 | input | 1 | Count enable of the toggle stage (bit 0) |
| cnt_c2 | input | 1 | Count enable of the five-state stage (bits 3..1) |
| set_bits | input | 4 | Per-bit force-to-one lines |
| clear_all | input | 1 | Common force-to-zero line |
| q | output | 4 | Counter bits, bit 3 down to bit 0 |
| q0_n | output | 1 | Complement of q[0] |
| q3_n | output | 1 | Complement of q[3] |
| tc | output | 1 | High at count 9 |

## Verification
The checker tests on every cycle that the complement outputs and the terminal flag agree with `q`, that active force lines show on `q` in the same cycle with set winning over clear, that an idle cycle leaves `q` unchanged, and that an out-of-sequence five-state value is gone after one advance. The bench scenarios are needed to show the full ten-step orders in each mode, the carry taking a different direction in each mode, a set or clear applied in the middle of a run, and counting resuming from the forced value.

// File: rtl/biq_pkg.sv
package biq_pkg;
    localparam int QUIN_W = 3;
    localparam int CNT_W  = QUIN_W + 1;
    localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;
    localparam logic [CNT_W-1:0]  TERM_VAL  = 4'b1001;

    typedef enum logic {
        CHAIN_BCD = 1'b0,
        CHAIN_BIQ = 1'b1
    } chain_mode_e;

    // Layout matches the output bus: {bit3, bit2, bit1} then bit0
    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              bin;
    } cnt_state_t;

    // Five-state successor; any value at or above the last legal one goes home
    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] v);
        if (v >= QUIN_LAST) return '0;
        return v + 1'b1;
    endfunction
endpackage

// File: rtl/biq_div2.sv
module biq_div2 (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  logic load_val,
    output logic q,
    output logic at_last
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= load_val;
        else if (adv)  q <= ~q;
    end

    assign at_last = q;
endmodule

// File: rtl/biq_div5.sv
module biq_div5
    import biq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              load,
    input  logic [QUIN_W-1:0] load_val,
    output logic [QUIN_W-1:0] v,
    output logic              at_last
);
    always_ff @(posedge clk) begin
        if (rst)       v <= '0;
        else if (load) v <= load_val;
        else if (adv)  v <= quin_next(v);
    end

    // Only the legal last state produces a carry; illegal states return silently
    assign at_last = (v == QUIN_LAST);
endmodule

// File: rtl/biq_force.sv
module biq_force
    import biq_pkg::*;
(
    input  cnt_state_t       held,
    input  logic [CNT_W-1:0] set_bits,
    input  logic             clear_all,
    output cnt_state_t       shown,
    output logic             force_on
);
    logic [CNT_W-1:0] held_v;
    assign held_v   = held;
    assign force_on = clear_all | (|set_bits);
    // Set wins over clear on a shared bit
    assign shown    = cnt_state_t'((held_v & ~{CNT_W{clear_all}}) | set_bits);
endmodule

// File: rtl/biq_counter.sv
module biq_counter
    import biq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    input  logic       cnt_c1,
    input  logic       cnt_c2,
    input  logic [3:0] set_bits,
    input  logic       clear_all,
    output logic [3:0] q,
    output logic       q0_n,
    output logic       q3_n,
    output logic       tc
);
    chain_mode_e chain;
    cnt_state_t  held, shown;
    logic        force_on;
    logic        bin_last, quin_last;
    logic        carry_up, carry_down;
    logic        adv_bin, adv_quin;

    assign chain = chain_mode_e'(mode);

    // Carries come from each stage's own pulse only, so no loop through the mux
    assign carry_up   = (chain == CHAIN_BCD) & cnt_c1 & bin_last;
    assign carry_down = (chain == CHAIN_BIQ) & cnt_c2 & quin_last;
    assign adv_bin    = cnt_c1 | carry_down;
    assign adv_quin   = cnt_c2 | carry_up;

    biq_div2 u_bin (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv_bin),
        .load    (force_on),
        .load_val(shown.bin),
        .q       (held.bin),
        .at_last (bin_last)
    );

    biq_div5 u_quin (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv_quin),
        .load    (force_on),
        .load_val(shown.quin),
        .v       (held.quin),
        .at_last (quin_last)
    );

    biq_force u_force (
        .held     (held),
        .set_bits (set_bits),
        .clear_all(clear_all),
        .shown    (shown),
        .force_on (force_on)
    );

    assign q    = shown;
    assign q0_n = ~shown.bin;
    assign q3_n = ~shown.quin[QUIN_W-1];
    assign tc   = (shown == TERM_VAL);
endmodule

// File: rtl/biq_counter_chk.sv
module biq_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_c1,
    input logic       cnt_c2,
    input logic [3:0] set_bits,
    input logic       clear_all,
    input logic [3:0] q,
    input logic       q0_n,
    input logic       q3_n,
    input logic       tc
);
    logic frc;
    assign frc = clear_all | (|set_bits);

    // R9
    comp_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (q0_n == ~q[0]) && (q3_n == ~q[3]));

    // R10
    term_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tc == (q == 4'b1001));

    // R5
    set_override_chk: assert property (@(posedge clk) disable iff (rst)
        |set_bits |-> ((q & set_bits) == set_bits));

    // R6
    clear_override_chk: assert property (@(posedge clk) disable iff (rst)
        clear_all |-> ((q & ~set_bits) == 4'b0000));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_c1 && !cnt_c2 && !frc) |=> (clear_all || (|set_bits) || q == $past(q)));

    // R8
    illegal_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (!frc && cnt_c2 && q[3] && (q[2] || q[1])) |=>
        (clear_all || (|set_bits) || q[3:1] == 3'b000));
endmodule

bind biq_counter biq_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_c1   (cnt_c1),
    .cnt_c2   (cnt_c2),
    .set_bits (set_bits),
    .clear_all(clear_all),
    .q        (q),
    .q0_n     (q0_n),
    .q3_n     (q3_n),
    .tc       (tc)
);

// File: tb/tb_biq_counter.sv
module tb_biq_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       cnt_c1 = 1'b0;
    logic       cnt_c2 = 1'b0;
    logic [3:0] set_bits = 4'b0000;
    logic       clear_all = 1'b0;
    logic [3:0] q;
    logic       q0_n, q3_n, tc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    biq_counter dut (
        .clk(clk), .rst(rst), .mode(mode), .cnt_c1(cnt_c1), .cnt_c2(cnt_c2),
        .set_bits(set_bits), .clear_all(clear_all),
        .q(q), .q0_n(q0_n), .q3_n(q3_n), .tc(tc)
    );

    task automatic check_q(input string req, input logic [3:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] biq_exp(input int n);
        logic [2:0] v;
        v = 3'(n % 5);
        return {v, (n >= 5)};
    endfunction

    // Inputs change on falling edges; results are read on the next falling edge
    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic pulse(input logic c1, input logic c2);
        @(negedge clk); cnt_c1 = c1; cnt_c2 = c2;
        @(negedge clk); cnt_c1 = 1'b0; cnt_c2 = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_q("R1", 4'b0000);
        check_bit("R1 q0_n", q0_n, 1'b1);
        check_bit("R1 q3_n", q3_n, 1'b1);
        check_bit("R1 tc", tc, 1'b0);
    endtask

    task automatic t_bcd_seq();
        mode = 1'b0; do_reset();
        for (int i = 1; i <= 25; i++) begin
            pulse(1'b1, 1'b0);
            check_q("R2", 4'(i % 10));
            check_bit("R10", tc, (i % 10) == 9);
            check_bit("R9", q3_n, ~q[3]);
        end
    endtask

    task automatic t_biq_seq();
        mode = 1'b1; do_reset();
        for (int i = 1; i <= 25; i++) begin
            pulse(1'b0, 1'b1);
            check_q("R3", biq_exp(i % 10));
            check_bit("R10", tc, (i % 10) == 9);
            check_bit("R9", q0_n, ~q[0]);
        end
    endtask

    task automatic t_stage_paths();
        // R4: bi-quinary mode, toggle stage wraps without carry
        mode = 1'b1; do_reset();
        pulse(1'b1, 1'b0); check_q("R4 biq c1", 4'b0001);
        pulse(1'b1, 1'b0); check_q("R4 biq c1 wrap", 4'b0000);
        // R4: BCD mode, five-state stage alone
        mode = 1'b0; do_reset();
        for (int i = 1; i <= 6; i++) begin
            pulse(1'b0, 1'b1);
            check_q("R4 bcd c2", {3'(i % 5), 1'b0});
        end
        // R4: carry and own pulse together advance once
        do_reset();
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1); check_q("R4 joint", 4'b0010);
    endtask

    task automatic t_force_mid();
        mode = 1'b0; do_reset();
        repeat (3) pulse(1'b1, 1'b0);
        @(negedge clk); set_bits = 4'b1000;
        #1 check_q("R5 async set", 4'b1011);
        clear_all = 1'b1; cnt_c1 = 1'b1;
        #1 check_q("R6 clear with set", 4'b1000);
        @(negedge clk); check_q("R7 frozen", 4'b1000);
        set_bits = 4'b0000; clear_all = 1'b0; cnt_c1 = 1'b0;
        #1 check_q("R7 held after release", 4'b1000);
        pulse(1'b1, 1'b0); check_q("R7 resume", 4'b1001);
        check_bit("R10 after force", tc, 1'b1);
        pulse(1'b1, 1'b0); check_q("R2 wrap after force", 4'b0000);
        // R6: set wins on a shared bit
        @(negedge clk); clear_all = 1'b1; set_bits = 4'b0001;
        #1 check_q("R6 set wins", 4'b0001);
        @(negedge clk); clear_all = 1'b0; set_bits = 4'b0000;
    endtask

    task automatic t_illegal();
        mode = 1'b1; do_reset();
        @(negedge clk); clear_all = 1'b1; set_bits = 4'b1010;
        @(negedge clk); clear_all = 1'b0; set_bits = 4'b0000;
        #1 check_q("R8 loaded", 4'b1010);
        pulse(1'b0, 1'b1); check_q("R8 recover no carry", 4'b0000);
        @(negedge clk); clear_all = 1'b1; set_bits = 4'b1101;
        @(negedge clk); clear_all = 1'b0; set_bits = 4'b0000;
        pulse(1'b0, 1'b1); check_q("R8 recover keeps bit0", 4'b0001);
    endtask

    task automatic t_idle();
        mode = 1'b0; do_reset();
        repeat (7) pulse(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check_q("R11 idle", 4'b0111);
    endtask

    initial begin
        t_reset();
        t_bcd_seq();
        t_biq_seq();
        t_stage_paths();
        t_force_mid();
        t_illegal();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule